// File: doc/BRIEF.md
# Branch Trace Nibble Output Unit

This block sits next to a processor core and turns change-of-flow events into a compact trace on two 4-bit ports. One port is a status code. The other carries data. When the core reports a taken branch, the status port shows the taken-branch code on the next cycle. If the event needs its target recorded, a length marker follows on the cycle after that. The marker says how many low bytes of the target address were captured.

The captured bytes go into a small nibble queue. The queue drains one nibble per clock onto the data port, lowest nibble first. Because of this queue, the status port can report later instructions while earlier target addresses are still being sent out. A capture is only taken when the whole address fits in the queue. If it does not fit, the block raises a stall request and holds the status port at the stall code until enough room frees up.

Top module: `flow_trace_unit`

## Requirements
- R1: A request that is accepted (`ev_valid_i` high, `trace_en_i` high, `stall_o` low) shows status code 0x5 on `pst_o` on the next cycle.
- R2: An accepted capture is followed one cycle after the 0x5 by a length marker on `pst_o`: 0x9 for `len_sel_i`=01, 0xA for 10 and 0xB for 11. `stall_o` is high during the cycle in which the marker is being produced.
- R3: `len_sel_i` selects how many low target-address bytes are captured: 01 gives 2 bytes (4 nibbles), 10 gives 3 bytes (6 nibbles) and 11 gives 4 bytes (8 nibbles). With 00, only the 0x5 is reported: there is no marker and no data.
- R4: Captured nibbles appear on `ddata_o` one per cycle, least significant first, so nibble k is address bits [4k+3:4k]. Captures leave the queue in the order they were accepted. When the queue was empty, the first nibble appears in the same cycle as the marker.
- R5: `ddata_o` is 0x0 on every cycle when the queue holds no nibble.
- R6: If a capture is requested while the free queue space is smaller than its nibble count, `stall_o` is high in that same cycle. Nothing is captured, and `pst_o` shows 0x0 on the next cycle (unless a marker is due).
- R7: On a cycle with no accepted request, no stall and no marker, `pst_o` shows the value `pst_core_i` had in the previous cycle. This holds while the queue is still draining.
- R8: With `trace_en_i` low, `ev_valid_i` is ignored: `pst_o` passes `pst_core_i` through, no data is queued, and no stall is raised.
- R9: With `ev_ok_i` low, an accepted request reports 0x5 but captures nothing and produces no marker.
- R10: After a synchronous reset, `pst_o` and `ddata_o` are 0x0, `stall_o` is low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pst_core_i | input | 4 | Status value passed through when no event is reported |
| ev_valid_i | input | 1 | Core reports a taken change of flow this cycle |
| ev_ok_i | input | 1 | The event is of a kind whose target may be captured |
| target_i | input | ADDR_W | Target address of the event |
| len_sel_i | input | 2 | Captured byte count: 00 none, 01 two, 10 three, 11 four |
| trace_en_i | input | 1 | Enables event reporting |
| pst_o | output | 4 | Registered status code |
| ddata_o | output | 4 | Registered trace data nibble |
| stall_o | output | 1 | Request to the core to hold its current event |

## Verification
The bench builds the block with its default sizes: a 16-nibble queue and a 32-bit address. With a queue that small, back-to-back 3-byte and 4-byte captures run out of space within a few events. This brings the stall path, the 0x0 status and the hand-off between stalled and resumed captures into reach. The bench sweeps every combination of enable, capture-allowed flag and length setting against shifting address patterns. It also runs all sixteen pass-through values, and it checks every status, data and stall value on every cycle against its own queue model.

// File: rtl/ftu_pkg.sv
package ftu_pkg;

  localparam logic [3:0] PST_HOLD  = 4'h0;
  localparam logic [3:0] PST_TAKEN = 4'h5;

  // marker for a length select: 01 -> 0x9, 10 -> 0xA, 11 -> 0xB
  function automatic logic [3:0] len_marker(input logic [1:0] sel);
    return {2'b10, sel};
  endfunction

  // nibbles captured for a length select; 00 captures nothing
  function automatic logic [3:0] len_nibbles(input logic [1:0] sel);
    return (sel == 2'b00) ? 4'd0 : ({1'b0, sel, 1'b0} + 4'd2);
  endfunction

endpackage

// File: rtl/ftu_addr_slicer.sv
module ftu_addr_slicer
  import ftu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NIB_N  = ADDR_W / 4,
  parameter int NW     = $clog2(NIB_N + 1)
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [1:0]                sel,
  input  logic                      take,
  output logic [NIB_N-1:0][3:0]     nibs,
  output logic [NW-1:0]             need
);

  for (genvar g = 0; g < NIB_N; g++) begin : g_nib
    assign nibs[g] = addr[4*g +: 4];
  end

  logic [3:0] raw_need;
  assign raw_need = take ? len_nibbles(sel) : 4'd0;

  always_comb begin
    if (32'(raw_need) > NIB_N) need = NW'(NIB_N);
    else                       need = NW'(raw_need);
  end

endmodule

// File: rtl/ftu_nibble_fifo.sv
module ftu_nibble_fifo #(
  parameter int DEPTH = 16,
  parameter int NIB_N = 8,
  parameter int NW    = $clog2(NIB_N + 1),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NW-1:0]         push_n,
  input  logic [NIB_N-1:0][3:0] din,
  output logic [3:0]            dout,
  output logic [CW-1:0]         count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [3:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          pop;

  assign pop = (count != '0);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NIB_N; i++) begin
      if (i < int'(push_n)) mem[wr_ptr + AW'(i)] <= din[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      dout   <= 4'h0;
    end else begin
      dout   <= pop ? mem[rd_ptr] : 4'h0;
      rd_ptr <= rd_ptr + AW'(pop);
      wr_ptr <= wr_ptr + AW'(push_n);
      count  <= count - CW'(pop) + CW'(push_n);
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push_n != '0) |-> (32'(count) + 32'(push_n) <= DEPTH));

  a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> (dout == 4'h0));

  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    32'(count) <= DEPTH);

endmodule

// File: rtl/ftu_status_seq.sv
module ftu_status_seq
  import ftu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NW    = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [NW-1:0] need,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] count,
  input  logic [3:0]    pst_core,
  output logic          stall,
  output logic          push_ok,
  output logic [3:0]    pst
);

  localparam int WW = ((CW > NW) ? CW : NW) + 1;

  logic       mark_pend;
  logic [3:0] mark_code;
  logic       fits;
  logic       accept;

  assign fits    = (WW'(count) + WW'(need)) <= WW'(DEPTH);
  assign stall   = mark_pend | ((need != '0) & ~fits);
  assign accept  = req & ~stall;
  assign push_ok = accept & (need != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_pend <= 1'b0;
      mark_code <= 4'h0;
      pst       <= PST_HOLD;
    end else begin
      mark_pend <= push_ok;
      mark_code <= len_marker(sel);
      if (mark_pend)   pst <= mark_code;
      else if (stall)  pst <= PST_HOLD;
      else if (accept) pst <= PST_TAKEN;
      else             pst <= pst_core;
    end
  end

  a_r1_taken_code: assert property (@(posedge clk) disable iff (rst)
    accept |=> (pst == PST_TAKEN));

  a_r2_marker_next: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> ##1 (pst[3:2] == 2'b10 && pst[1:0] != 2'b00));

  a_r6_hold_code: assert property (@(posedge clk) disable iff (rst)
    (stall && !mark_pend) |=> (pst == PST_HOLD));

  a_r2_no_double_take: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> !push_ok);

endmodule

// File: rtl/flow_trace_unit.sv
module flow_trace_unit #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        pst_core_i,
  input  logic              ev_valid_i,
  input  logic              ev_ok_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [1:0]        len_sel_i,
  input  logic              trace_en_i,
  output logic [3:0]        pst_o,
  output logic [3:0]        ddata_o,
  output logic              stall_o
);

  localparam int NIB_N = ADDR_W / 4;
  localparam int NW    = $clog2(NIB_N + 1);
  localparam int CW    = $clog2(DEPTH + 1);

  logic                  req;
  logic [NIB_N-1:0][3:0] nibs;
  logic [NW-1:0]         need;
  logic [NW-1:0]         push_n;
  logic [CW-1:0]         count;
  logic                  push_ok;

  assign req    = ev_valid_i & trace_en_i;
  assign push_n = push_ok ? need : '0;

  ftu_addr_slicer #(.ADDR_W(ADDR_W), .NIB_N(NIB_N), .NW(NW)) u_slice (
    .addr (target_i),
    .sel  (len_sel_i),
    .take (req & ev_ok_i),
    .nibs (nibs),
    .need (need)
  );

  ftu_status_seq #(.DEPTH(DEPTH), .NW(NW), .CW(CW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .need     (need),
    .sel      (len_sel_i),
    .count    (count),
    .pst_core (pst_core_i),
    .stall    (stall_o),
    .push_ok  (push_ok),
    .pst      (pst_o)
  );

  ftu_nibble_fifo #(.DEPTH(DEPTH), .NIB_N(NIB_N), .NW(NW), .CW(CW)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .push_n (push_n),
    .din    (nibs),
    .dout   (ddata_o),
    .count  (count)
  );

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!trace_en_i && !stall_o) |=> (pst_o == $past(pst_core_i)));

endmodule

// File: tb/flow_trace_unit_test.sv
module flow_trace_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  pst_core_i;
  logic        ev_valid_i;
  logic        ev_ok_i;
  logic [31:0] target_i;
  logic [1:0]  len_sel_i;
  logic        trace_en_i;
  logic [3:0]  pst_o;
  logic [3:0]  ddata_o;
  logic        stall_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [3:0] mq[$];
  bit         m_pend;
  logic [3:0] m_code;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flow_trace_unit uut (
    .clk(clk), .rst(rst), .pst_core_i(pst_core_i), .ev_valid_i(ev_valid_i),
    .ev_ok_i(ev_ok_i), .target_i(target_i), .len_sel_i(len_sel_i),
    .trace_en_i(trace_en_i), .pst_o(pst_o), .ddata_o(ddata_o), .stall_o(stall_o)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs already driven; ends at the following falling edge
  task automatic step();
    bit req, st, acc;
    int need;
    logic [3:0] e_pst, e_dd;
    string pt;
    #1;
    req  = ev_valid_i && trace_en_i;
    need = (req && ev_ok_i && len_sel_i != 2'b00) ? 2 * int'(len_sel_i) + 2 : 0;
    st   = m_pend || (need != 0 && mq.size() + need > DEPTH);
    acc  = req && !st;
    chk(m_pend ? "R2 stall in marker cycle" : "R6 stall", {3'b0, stall_o}, {3'b0, st});
    if (m_pend)   begin e_pst = m_code; pt = "R2 R3 marker"; end
    else if (st)  begin e_pst = 4'h0;   pt = "R6 hold code"; end
    else if (acc) begin e_pst = 4'h5;   pt = (ev_ok_i ? "R1 taken" : "R9 taken no capture"); end
    else          begin e_pst = pst_core_i; pt = (ev_valid_i ? "R8 ignored" : "R7 pass"); end
    if (mq.size() != 0) e_dd = mq.pop_front();
    else                e_dd = 4'h0;
    if (acc && need != 0) begin
      for (int k = 0; k < need; k++) mq.push_back(target_i[4*k +: 4]);
      m_pend = 1;
      m_code = {2'b10, len_sel_i};
    end else begin
      m_pend = 0;
    end
    @(negedge clk);
    chk(pt, pst_o, e_pst);
    chk(e_dd == 4'h0 && mq.size() == 0 ? "R5 empty or R4 data" : "R4 nibble", ddata_o, e_dd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      ev_valid_i = 0;
      pst_core_i = 4'(i * 7 + 3);
      step();
    end
  endtask

  // core behaviour: hold the event while stall_o is high
  task automatic issue(input bit ok, input logic [1:0] sel, input logic [31:0] a);
    bit was_stalled;
    ev_valid_i = 1; ev_ok_i = ok; len_sel_i = sel; target_i = a;
    for (int i = 0; i < 64; i++) begin
      pst_core_i = 4'(i + 1);
      #1 was_stalled = stall_o;
      step();
      if (!was_stalled) break;
    end
    ev_valid_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; pst_core_i = 4'h7; ev_valid_i = 0; ev_ok_i = 0;
    target_i = '0; len_sel_i = 0; trace_en_i = 1;
    m_pend = 0;
    @(negedge clk); @(negedge clk);
    chk("R10 reset pst", pst_o, 4'h0);
    chk("R10 reset ddata", ddata_o, 4'h0);
    chk("R10 reset stall", {3'b0, stall_o}, 4'h0);
    rst = 0;

    // R7: every pass-through value
    for (int v = 0; v < 16; v++) begin
      pst_core_i = 4'(v);
      step();
    end

    // sweep enable x allowed x length select
    for (int en = 0; en < 2; en++)
      for (int s = 0; s < 4; s++)
        for (int ok = 0; ok < 2; ok++) begin
          trace_en_i = en[0];
          issue(ok[0], 2'(s), 32'h89AB_CDEF ^ (32'h1357_9BDF * 32'(en * 8 + s * 2 + ok)));
          idle(3);
        end
    idle(10);

    // back-to-back captures to run out of queue space (R6)
    trace_en_i = 1;
    for (int s = 1; s < 4; s++) begin
      for (int j = 0; j < 6; j++)
        issue(1, 2'(s), 32'hF0E1_D2C3 + 32'h0101_0101 * 32'(j + 4 * s));
      // disable while data still drains (R8, R7)
      trace_en_i = 0;
      issue(1, 2'b11, 32'h1234_5678);
      trace_en_i = 1;
      idle(40);
    end

    // mixed lengths back to back, order across captures (R4)
    issue(1, 2'b01, 32'h0000_A5C3);
    issue(0, 2'b11, 32'hFFFF_FFFF);
    issue(1, 2'b11, 32'h7654_3210);
    issue(1, 2'b10, 32'h00BE_EF01);
    idle(30);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule